// File: doc/BRIEF.md
# Memory Auto-Sleep Controller

This block sits in front of a RAM that has one write port and one read port. It decides when the RAM may drop into a low-power state, and it makes sure the RAM is awake again before the next access reaches it. Every request-side signal of both ports passes through a register pipeline whose depth equals the idle threshold `IDLE_THR`. The only exception is the synchronous reset of the read output register. Because of this pipeline, the controller sees each access `IDLE_THR` cycles before the RAM does.

The controller counts consecutive idle cycles on the undelayed inputs. A run of at least `IDLE_THR` idle cycles produces a sleep window on the memory side. The window starts when the first idle cycle of the run comes out of the pipeline. It lasts the run length minus three cycles, so the RAM has three awake cycles before the delayed access arrives. The read latency seen by the user therefore grows by `IDLE_THR` cycles on top of the RAM's own latency.

Setting `IDLE_THR` to 0 turns the feature off: the ports are wired straight through and sleep never asserts. A nonzero threshold must lie between 4 and 15. The controller also reports how many sleep cycles have passed in the current or most recent sleep episode.

Top module: `mem_autosleep_ctrl`

## Requirements
- R1: With `IDLE_THR` = 0, every memory-side output equals its port input in the same cycle, `mem_sleep_o` stays 0 and `sleep_len_o` stays 0.
- R2: With `IDLE_THR` = T > 0, each write-side and read-side request output equals the matching input from exactly T cycles earlier. Outputs read 0 during the first T cycles after reset. `mem_rd_rst_o` follows `rd_rst_i` with no delay.
- R3: A cycle is active when `rd_en_i` is 1, or when `wr_en_i` is 1 with at least one bit of `wr_mask_i` set. A write enable with an all-zero mask, and any value of `rd_oce_i`, leaves the cycle idle.
- R4: An idle run shorter than T cycles gives no sleep cycles.
- R5: An idle run of L ≥ T cycles starting at input cycle t gives exactly L−3 consecutive sleep cycles, starting in cycle t+T.
- R6: Whenever a delayed access reaches the memory side, `mem_sleep_o` was 0 in each of the three preceding cycles.
- R7: `sleep_len_o` reads 1 in the cycle after sleep rises. It then increases by one for each further sleep cycle, saturating at its maximum, and holds its value while sleep is low.
- R8: While `rst_n` is low, all delayed outputs, `mem_sleep_o` and `sleep_len_o` are 0, and idle counting restarts when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write port enable |
| wr_mask_i | input | MASK_W | Per-lane write mask |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read port enable |
| rd_addr_i | input | ADDR_W | Read address |
| rd_oce_i | input | 1 | Read output register clock enable |
| rd_rst_i | input | 1 | Read output register reset (not delayed) |
| mem_wr_en_o | output | 1 | Delayed write enable |
| mem_wr_mask_o | output | MASK_W | Delayed write mask |
| mem_wr_addr_o | output | ADDR_W | Delayed write address |
| mem_wr_data_o | output | DATA_W | Delayed write data |
| mem_rd_en_o | output | 1 | Delayed read enable |
| mem_rd_addr_o | output | ADDR_W | Delayed read address |
| mem_rd_oce_o | output | 1 | Delayed output register enable |
| mem_rd_rst_o | output | 1 | Output register reset, passed through |
| mem_sleep_o | output | 1 | Sleep request to the memory |
| sleep_len_o | output | LEN_W | Sleep cycles in current or last episode |

## Verification
Idle runs of every length from 1 up to past the threshold are tried, each separated by a single access. Run lengths just below, at and above T separate an off-by-one in the qualifying count from an off-by-one in the minus-three window. Runs that are filled with zero-mask writes and toggling output enables show whether the activity rule counts only real accesses. Back-to-back accesses, a mid-run reset and a zero-threshold instance fed the same stimulus cover the pipeline alignment, the restart of counting and the bypass path.

// File: rtl/mas_pkg.sv
package mas_pkg;
  // awake cycles guaranteed ahead of a delayed access
  localparam int unsigned WAKE_LEAD = 3;
  // smallest usable nonzero idle threshold
  localparam int unsigned MIN_THR   = WAKE_LEAD + 1;
  localparam int unsigned MAX_THR   = 15;
endpackage

// File: rtl/mas_delay_line.sv
module mas_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/mas_idle_tracker.sv
module mas_idle_tracker #(
  parameter int unsigned THR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(THR + 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(THR);
  localparam logic [CW-1:0] CNT_LAST = CW'(THR - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hit;

  // saturating count of consecutive idle cycles; hit marks the cycle
  // in which the run first reaches the threshold
  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (active_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_TOP) begin
      cnt_d = cnt_q + 1'b1;
      hit   = (cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit_o = hit;

  // R4
  run_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);
  // R3
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> (cnt_q == '0));
endmodule

// File: rtl/mas_sleep_gate.sv
module mas_sleep_gate #(
  parameter int unsigned THR   = 8,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             hit_i,
  output logic             sleep_o,
  output logic [LEN_W-1:0] sleep_len_o
);
  import mas_pkg::*;

  // activity history tapped so that sleep ends WAKE_LEAD cycles
  // before the delayed access leaves the pipeline
  localparam int unsigned HD = THR - WAKE_LEAD;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [HD-1:0]    hist_q, hist_d;
  logic             qual_q, qual_d;
  logic             prev_q;
  logic [LEN_W-1:0] len_q, len_d;
  logic             tap_busy;
  logic             sleep;

  assign tap_busy = hist_q[HD-1];
  assign sleep    = qual_q & ~tap_busy;

  always_comb begin
    hist_d[0] = active_i;
    for (int i = 1; i < HD; i++) hist_d[i] = hist_q[i-1];
  end

  always_comb begin
    qual_d = hit_i | (qual_q & ~tap_busy);
  end

  always_comb begin
    len_d = len_q;
    if (sleep && !prev_q)                 len_d = {{(LEN_W-1){1'b0}}, 1'b1};
    else if (sleep && (len_q != LEN_MAX)) len_d = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      qual_q <= 1'b0;
      prev_q <= 1'b0;
      len_q  <= '0;
    end else begin
      hist_q <= hist_d;
      qual_q <= qual_d;
      prev_q <= sleep;
      len_q  <= len_d;
    end
  end

  assign sleep_o     = sleep;
  assign sleep_len_o = len_q;

  // R7
  len_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !prev_q) |=> (len_q == {{(LEN_W-1){1'b0}}, 1'b1}));
  // R7
  len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && prev_q && len_q != LEN_MAX) |=> (len_q == $past(len_q) + 1'b1));
  // R7
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> $stable(len_q));
endmodule

// File: rtl/mem_autosleep_ctrl.sv
module mem_autosleep_ctrl #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MASK_W   = 4,
  parameter int unsigned IDLE_THR = 8,
  parameter int unsigned LEN_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_oce_i,
  input  logic              rd_rst_i,
  output logic              mem_wr_en_o,
  output logic [MASK_W-1:0] mem_wr_mask_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic              mem_rd_oce_o,
  output logic              mem_rd_rst_o,
  output logic              mem_sleep_o,
  output logic [LEN_W-1:0]  sleep_len_o
);
  localparam int unsigned VEC_W = 3 + MASK_W + 2 * ADDR_W + DATA_W;

  logic [VEC_W-1:0] port_vec, mem_vec;
  logic             req_active;

  assign port_vec   = {wr_en_i, wr_mask_i, wr_addr_i, wr_data_i,
                       rd_en_i, rd_addr_i, rd_oce_i};
  assign req_active = (wr_en_i & (|wr_mask_i)) | rd_en_i;

  assign {mem_wr_en_o, mem_wr_mask_o, mem_wr_addr_o, mem_wr_data_o,
          mem_rd_en_o, mem_rd_addr_o, mem_rd_oce_o} = mem_vec;

  // output register reset is never delayed
  assign mem_rd_rst_o = rd_rst_i;

  generate
    if (IDLE_THR == 0) begin : g_bypass
      assign mem_vec     = port_vec;
      assign mem_sleep_o = 1'b0;
      assign sleep_len_o = '0;
    end else begin : g_sleep
      logic run_hit;
      logic mem_access;

      mas_delay_line #(.W(VEC_W), .DEPTH(IDLE_THR)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (port_vec),
        .q_o   (mem_vec)
      );

      mas_idle_tracker #(.THR(IDLE_THR)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (req_active),
        .hit_o    (run_hit)
      );

      mas_sleep_gate #(.THR(IDLE_THR), .LEN_W(LEN_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (req_active),
        .hit_i       (run_hit),
        .sleep_o     (mem_sleep_o),
        .sleep_len_o (sleep_len_o)
      );

      assign mem_access = mem_rd_en_o | (mem_wr_en_o & (|mem_wr_mask_o));

      // R6
      wake_margin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_access |-> (!$past(mem_sleep_o) && !$past(mem_sleep_o, 2)
                        && !$past(mem_sleep_o, 3)));
      // R5
      sleep_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sleep_o |-> !mem_access);
    end
  endgenerate
endmodule

// File: tb/mem_autosleep_ctrl_bench.sv
module mem_autosleep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int MW = 2;
  localparam int T  = 6;
  localparam int LW = 8;
  localparam int VW = 3 + MW + 2 * AW + DW;
  localparam int NMAX = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, oce = 1'b0, rrst = 1'b0;
  logic [MW-1:0] mask = '0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;

  logic dut_we, dut_re, dut_oce, dut_rrst, dut_sleep;
  logic [MW-1:0] dut_mask;
  logic [AW-1:0] dut_wa, dut_ra;
  logic [DW-1:0] dut_wd;
  logic [LW-1:0] dut_len;
  logic pt_we, pt_re, pt_oce, pt_rrst, pt_sleep;
  logic [MW-1:0] pt_mask;
  logic [AW-1:0] pt_wa, pt_ra;
  logic [DW-1:0] pt_wd;
  logic [LW-1:0] pt_len;
  logic [VW-1:0] dut_vec, pt_vec;

  assign dut_vec = {dut_we, dut_mask, dut_wa, dut_wd, dut_re, dut_ra, dut_oce};
  assign pt_vec  = {pt_we, pt_mask, pt_wa, pt_wd, pt_re, pt_ra, pt_oce};

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_autosleep_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MASK_W(MW), .IDLE_THR(T), .LEN_W(LW))
  u_mem_autosleep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_mask_i(mask), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_en_i(rd_en), .rd_addr_i(ra), .rd_oce_i(oce), .rd_rst_i(rrst),
    .mem_wr_en_o(dut_we), .mem_wr_mask_o(dut_mask), .mem_wr_addr_o(dut_wa),
    .mem_wr_data_o(dut_wd), .mem_rd_en_o(dut_re), .mem_rd_addr_o(dut_ra),
    .mem_rd_oce_o(dut_oce), .mem_rd_rst_o(dut_rrst), .mem_sleep_o(dut_sleep),
    .sleep_len_o(dut_len));

  mem_autosleep_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MASK_W(MW), .IDLE_THR(0), .LEN_W(LW))
  u_mem_autosleep_ctrl_pt (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_mask_i(mask), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_en_i(rd_en), .rd_addr_i(ra), .rd_oce_i(oce), .rd_rst_i(rrst),
    .mem_wr_en_o(pt_we), .mem_wr_mask_o(pt_mask), .mem_wr_addr_o(pt_wa),
    .mem_wr_data_o(pt_wd), .mem_rd_en_o(pt_re), .mem_rd_addr_o(pt_ra),
    .mem_rd_oce_o(pt_oce), .mem_rd_rst_o(pt_rrst), .mem_sleep_o(pt_sleep),
    .sleep_len_o(pt_len));

  int checks = 0;
  int errors = 0;
  int j = 0;
  int seed = 1;
  int exp_len = 0;
  bit release_now = 1'b0;
  logic [VW-1:0] in_hist [NMAX];
  bit act_h [NMAX];
  bit exp_s [NMAX];
  bit obs_s [NMAX];
  int run_t0 [64];
  int run_len [64];
  int run_kind [64];
  int nruns = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", what, j, act, exp);
    end
  endtask

  // reference: memory-side cycle m sleeps when input cycle m-T and the next
  // three are idle and the idle run holding them lasted at least T cycles
  function automatic bit exp_sleep(input int m);
    int u, t0;
    u = m - T;
    if (u < 0) return 1'b0;
    for (int k = u; k <= u + 3; k++) if (act_h[k]) return 1'b0;
    t0 = u;
    while (t0 > 0 && !act_h[t0-1]) t0--;
    for (int k = t0; k < t0 + T; k++) if (act_h[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_cycle();
    logic [VW-1:0] ev;
    bit s1, s2;
    ev = (j >= T) ? in_hist[j-T] : '0;
    // R2 delayed bundle and undelayed output reset
    chk(dut_vec === ev, "R2 delayed ports", longint'(dut_vec), longint'(ev));
    chk(dut_rrst === rrst, "R2 reset passthrough", longint'(dut_rrst), longint'(rrst));
    // R5 per-cycle sleep against the reference
    exp_s[j] = exp_sleep(j);
    obs_s[j] = dut_sleep;
    chk(dut_sleep === exp_s[j], "R5 sleep", longint'(dut_sleep), longint'(exp_s[j]));
    // R7 episode length
    s1 = (j >= 1) ? exp_s[j-1] : 1'b0;
    s2 = (j >= 2) ? exp_s[j-2] : 1'b0;
    if (s1 && !s2) exp_len = 1;
    else if (s1 && exp_len < 255) exp_len++;
    chk(dut_len === LW'(exp_len), "R7 sleep length", longint'(dut_len), longint'(exp_len));
    // R6 wake margin before a delayed access
    if (j >= T && act_h[j-T]) begin
      for (int k = j - 3; k < j; k++)
        if (k >= 0) chk(obs_s[k] == 1'b0, "R6 awake before access", longint'(obs_s[k]), 0);
    end
    // R1 zero-threshold instance
    if (j >= 1) begin
      chk(pt_vec === in_hist[j-1], "R1 bypass ports", longint'(pt_vec), longint'(in_hist[j-1]));
      chk(pt_sleep === 1'b0 && pt_len === '0, "R1 bypass sleep",
          longint'({pt_sleep, pt_len}), 0);
    end
    // per-run sleep totals: R3 zero-mask runs, R4 short runs, R5 long runs
    for (int r = 0; r < nruns; r++) begin
      if (run_t0[r] + run_len[r] + T == j) begin
        int cnt;
        int want;
        string tag;
        cnt = 0;
        for (int k = run_t0[r] + T; k < j; k++) cnt += int'(obs_s[k]);
        want = (run_len[r] >= T) ? run_len[r] - 3 : 0;
        tag = (run_kind[r] != 0) ? "R3 zero-mask run sleep count" :
              (run_len[r] < T) ? "R4 short run sleep count" : "R5 run sleep count";
        chk(cnt == want, tag, longint'(cnt), longint'(want));
      end
    end
  endtask

  task automatic step(input bit we, input logic [MW-1:0] m, input bit re,
                      input bit oc, input bit rr);
    @(negedge clk);
    check_cycle();
    if (release_now) begin
      rst_n = 1'b1;
      release_now = 1'b0;
    end
    seed = seed * 1103 + 12345;
    wr_en = we; mask = m; rd_en = re; oce = oc; rrst = rr;
    wa = AW'(seed >> 3); ra = AW'(seed >> 9); wd = DW'(seed >> 5);
    in_hist[j] = {wr_en, mask, wa, wd, rd_en, ra, oce};
    act_h[j] = (we && m != '0) || re;
    j++;
  endtask

  task automatic active(input int n);
    for (int i = 0; i < n; i++) begin
      if ((j % 2) == 0) step(1'b1, (j % 4 == 0) ? 2'b11 : 2'b01, 1'b0, 1'b1, seed[4]);
      else              step(1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic idle(input int n, input int kind);
    run_t0[nruns] = j; run_len[nruns] = n; run_kind[nruns] = kind; nruns++;
    for (int i = 0; i < n; i++) step(kind != 0, 2'b00, 1'b0, (kind != 0) && i[0], 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; oce = 1'b0; rrst = 1'b0; mask = '0;
    #1;
    // R8 outputs cleared while reset is low
    chk(dut_vec === '0, "R8 reset ports", longint'(dut_vec), 0);
    chk(dut_sleep === 1'b0, "R8 reset sleep", longint'(dut_sleep), 0);
    chk(dut_len === '0, "R8 reset length", longint'(dut_len), 0);
    repeat (2) @(negedge clk);
    j = 0; nruns = 0; exp_len = 0;
    release_now = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: run did not complete (actual timeout, expected finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    active(3);
    for (int l = 1; l <= 8; l++) begin
      idle(l, 0);
      active(1);
    end
    idle(11, 0); active(1);
    idle(16, 0); active(1);
    idle(30, 0); active(1);
    idle(10, 1); active(1);
    idle(6, 1);  active(4);
    idle(9, 0);  active(T + 4);
    idle(5, 0);
    do_reset();
    active(1);
    idle(7, 0);
    active(12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule